// File: doc/BRIEF.md
# Host Parallel Frame Receiver

This block sits on the device side of an 8-bit parallel link that a host controller uses to push data blocks. The host raises its request line and presents a byte. The device raises a ready line whenever it can take that byte. Each byte moved under the handshake goes into a small frame buffer. When the buffer holds a whole frame, the device pulls its more-data line low. That tells the host the block has ended.

The host must then drop its request. The frame stays held until a downstream consumer has read it through a registered read port and pulsed a release strobe. Only when the consumer has released the frame and the request line is low does the more-data line go high again. From that point the next block may begin. The data byte is a fixed slice of a wider host bus, and the slice position is a parameter. If the host starts a new request while the frame is closed, a sticky error flag is raised and no data is taken.

Top module: `hdma_frame_rx`

## Requirements
- R1: While `rst` is high, at each clock edge `dev_ready` goes low, `dev_more` goes high, and `frame_valid` and `overrun_err` go low.
- R2: On the first clock edge after `rst` falls, `dev_ready` rises.
- R3: A byte is taken on a clock edge where `host_req` and `dev_ready` are both high. `dev_ready` is low for the following cycle. If the frame is not yet complete, `dev_ready` rises again on the edge after that.
- R4: The byte taken is `host_bus[BUS_LSB+7:BUS_LSB]`. The k-th byte of a frame (k counting from 0) is returned on `rd_data` one clock after `rd_addr` is set to k.
- R5: On the edge that takes the FRAME_BYTES-th byte, `dev_more` goes low and `frame_valid` goes high. `dev_ready` stays low for as long as `dev_more` is low.
- R6: `dev_more` rises again, and `frame_valid` falls, on the first edge where `host_req` is low and `frame_release` is high now or was high on an earlier edge of the same closed frame. The next frame then fills from position 0.
- R7: A `frame_release` pulse given while `frame_valid` is low has no effect. The following frame still waits for a fresh release.
- R8: A rise of `host_req` (low on the previous edge, high on this one) while `dev_more` is low sets `overrun_err`. It stays set until reset. The bus data is not stored and the held frame is unchanged.
- R9: While `dev_more` is low and `host_req` stays high, `dev_more` stays low even after a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host transfer request |
| host_bus | input | BUS_W | Host bus; the data byte sits at BUS_LSB |
| dev_ready | output | 1 | Device ready for a byte |
| dev_more | output | 1 | High while the frame is open, low once it is complete |
| frame_valid | output | 1 | Complete frame held for the consumer |
| frame_release | input | 1 | Consumer strobe: the frame has been taken |
| rd_addr | input | ADDR_W | Consumer read position |
| rd_data | output | 8 | Registered read data |
| overrun_err | output | 1 | Sticky error: request restarted while the frame was closed |

## Verification
The bench builds the block with a 4-byte frame on a 12-bit host bus, with the data slice starting at bit 3. The short frame allows several complete frames, and every closing corner, to be driven within a few hundred cycles. The odd slice offset means that a wrong slice, or bits leaking from either side of it, show up in the bytes read back. Release before completion, release while the request is still held, and a premature request restart are each driven against a closed frame.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_WAIT = 2'd1,
    ST_FULL = 2'd2
  } rx_state_t;
endpackage

// File: rtl/hdma_frame_store.sv
module hdma_frame_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: simple dual-port RAM style so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/hdma_req_monitor.sv
module hdma_req_monitor (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic frame_closed,
  output logic err_flag
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      req_q <= host_req;
      // A fresh request while the frame is closed is a protocol error (R8)
      if (host_req && !req_q && frame_closed) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/hdma_handshake_fsm.sv
module hdma_handshake_fsm
  import hdma_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              frame_release,
  output logic              ready_o,
  output logic              more_o,
  output logic              frame_valid_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(DEPTH - 1);

  rx_state_t         st;
  logic [ADDR_W-1:0] fill_pos;
  logic              rel_seen;
  logic              rel_now;

  assign wr_en   = host_req && ready_o;
  assign wr_addr = fill_pos;
  assign rel_now = frame_release || rel_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_ARM;
      ready_o       <= 1'b0;
      more_o        <= 1'b1;
      frame_valid_o <= 1'b0;
      fill_pos      <= '0;
      rel_seen      <= 1'b0;
    end else begin
      case (st)
        ST_ARM: begin
          ready_o <= 1'b1;
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (host_req) begin
            ready_o <= 1'b0;
            if (fill_pos == LAST_POS) begin
              more_o        <= 1'b0;
              frame_valid_o <= 1'b1;
              rel_seen      <= 1'b0;
              st            <= ST_FULL;
            end else begin
              fill_pos <= fill_pos + 1'b1;
              st       <= ST_ARM;
            end
          end
        end
        ST_FULL: begin
          if (frame_release) rel_seen <= 1'b1;
          if (rel_now && !host_req) begin
            more_o        <= 1'b1;
            frame_valid_o <= 1'b0;
            fill_pos      <= '0;
            rel_seen      <= 1'b0;
            st            <= ST_ARM;
          end
        end
        default: st <= ST_ARM;
      endcase
    end
  end
endmodule

// File: rtl/hdma_frame_rx.sv
module hdma_frame_rx #(
  parameter int BUS_W       = 20,
  parameter int BUS_LSB     = 12,
  parameter int FRAME_BYTES = 10,
  parameter int ADDR_W      = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic [BUS_W-1:0]  host_bus,
  output logic              dev_ready,
  output logic              dev_more,
  output logic              frame_valid,
  input  logic              frame_release,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              overrun_err
);
  localparam int DATA_W = 8;

  logic [DATA_W-1:0] bus_byte;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              unused_bus_bits;

  assign bus_byte        = host_bus[BUS_LSB +: DATA_W];
  assign unused_bus_bits = ^host_bus;

  hdma_handshake_fsm #(
    .DEPTH  (FRAME_BYTES),
    .ADDR_W (ADDR_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .host_req      (host_req),
    .frame_release (frame_release),
    .ready_o       (dev_ready),
    .more_o        (dev_more),
    .frame_valid_o (frame_valid),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr)
  );

  hdma_frame_store #(
    .DATA_W (DATA_W),
    .DEPTH  (FRAME_BYTES),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (bus_byte),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  hdma_req_monitor u_mon (
    .clk          (clk),
    .rst          (rst),
    .host_req     (host_req),
    .frame_closed (!dev_more),
    .err_flag     (overrun_err)
  );
endmodule

// File: rtl/hdma_frame_rx_chk.sv
module hdma_frame_rx_chk (
  input logic clk,
  input logic rst,
  input logic host_req,
  input logic dev_ready,
  input logic dev_more,
  input logic frame_valid,
  input logic overrun_err
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!dev_ready && dev_more && !frame_valid && !overrun_err));

  p_ready_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (host_req && dev_ready) |=> !dev_ready);

  p_no_ready_closed_r5: assert property (@(posedge clk) disable iff (rst)
    !dev_more |-> !dev_ready);

  p_reopen_req_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_more) |-> $past(!host_req));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun_err |=> overrun_err);

  p_hold_closed_r9: assert property (@(posedge clk) disable iff (rst)
    (!dev_more && host_req) |=> !dev_more);
endmodule

bind hdma_frame_rx hdma_frame_rx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_req    (host_req),
  .dev_ready   (dev_ready),
  .dev_more    (dev_more),
  .frame_valid (frame_valid),
  .overrun_err (overrun_err)
);

// File: tb/test_hdma_frame_rx.sv
module test_hdma_frame_rx;
  localparam int BUS_W = 12;
  localparam int LSB   = 3;
  localparam int FB    = 4;
  localparam int AW    = 2;

  // {bus value, expected byte at bits [10:3]}
  localparam logic [19:0] VEC [8] = '{
    {12'hFFF, 8'hFF}, {12'h008, 8'h01}, {12'h807, 8'h00}, {12'h555, 8'hAA},
    {12'hAAA, 8'h55}, {12'h123, 8'h24}, {12'h7F8, 8'hFF}, {12'h3C0, 8'h78}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             host_req = 1'b0;
  logic [BUS_W-1:0] host_bus = '0;
  logic             frame_release = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic             dev_ready, dev_more, frame_valid, overrun_err;
  logic [7:0]       rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hdma_frame_rx #(.BUS_W(BUS_W), .BUS_LSB(LSB), .FRAME_BYTES(FB)) i_hdma_frame_rx (
    .clk(clk), .rst(rst), .host_req(host_req), .host_bus(host_bus),
    .dev_ready(dev_ready), .dev_more(dev_more), .frame_valid(frame_valid),
    .frame_release(frame_release), .rd_addr(rd_addr), .rd_data(rd_data),
    .overrun_err(overrun_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [BUS_W-1:0] v);
    host_bus = v;
    host_req = 1'b1;
    while (!dev_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_pos(input int k, input int exp, input string req);
    rd_addr = AW'(k);
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic pulse_release();
    frame_release = 1'b1;
    @(negedge clk);
    frame_release = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready", dev_ready, 0);
    check("R1 more", dev_more, 1);
    check("R1 valid", frame_valid, 0);
    check("R1 err", overrun_err, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 ready after reset", dev_ready, 1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // Vector loop: two frames of four bytes
    for (int f = 0; f < 2; f++) begin
      for (int b = 0; b < FB; b++) begin
        send_byte(VEC[f*FB+b][19:8]);
        check("R3 ready gap", dev_ready, 0);
      end
      check("R5 more low", dev_more, 0);
      check("R5 valid high", frame_valid, 1);
      host_req = 1'b0;
      @(negedge clk);
      check("R5 ready low while closed", dev_ready, 0);
      for (int b = 0; b < FB; b++) read_pos(b, VEC[f*FB+b][7:0], "R4 byte");
      check("R6 still closed before release", dev_more, 0);
      pulse_release();
      check("R6 more reopens", dev_more, 1);
      check("R6 valid falls", frame_valid, 0);
      @(negedge clk);
      check("R3 ready returns", dev_ready, 1);
    end

    // R7: early release ignored
    pulse_release();
    for (int b = 0; b < FB; b++) send_byte(12'h100 + 12'(b*8));
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 early release ignored", dev_more, 0);
    read_pos(0, 8'h20, "R6 new frame from position 0");
    pulse_release();
    check("R7 reopen after fresh release", dev_more, 1);
    @(negedge clk);

    // R9: request held across release, then release latched (R6)
    for (int b = 0; b < FB; b++) send_byte(12'h010);
    pulse_release();
    @(negedge clk);
    check("R9 held request keeps closed", dev_more, 0);
    host_req = 1'b0;
    @(negedge clk);
    check("R6 latched release reopens", dev_more, 1);
    @(negedge clk);

    // R8: premature request restart
    for (int b = 0; b < FB; b++) send_byte(12'h3F8 - 12'(b*8));
    host_req = 1'b0;
    @(negedge clk);
    check("R8 no error yet", overrun_err, 0);
    host_bus = 12'h000;
    host_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 error set", overrun_err, 1);
    check("R8 ready stays low", dev_ready, 0);
    host_req = 1'b0;
    read_pos(0, 8'h7F, "R8 frame unchanged");
    read_pos(3, 8'h7C, "R8 frame unchanged");
    pulse_release();
    check("R8 reopen", dev_more, 1);
    repeat (2) @(negedge clk);
    check("R8 error sticky", overrun_err, 1);

    do_reset();
    check("R1 error cleared by reset", overrun_err, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule